// File: doc/BRIEF.md
# Priority Two-Port Request Scheduler

This block sits between three polynomial-memory clients and a memory that has two internal access ports. Every cycle it looks at up to two access descriptors from each client and decides which of them reach the two ports. Client 0 (P) always wins, client 1 (H) comes next, and client 2 (X) comes last. The highest-priority client that can legally go takes port 0. If that client asks for only one access, one more access from a lower-priority client may take port 1. That second access is allowed only when it cannot collide with the first.

A client that presents two descriptors in the same cycle owns both ports atomically, or it does not go at all. This covers a combined read and write, and P's primary with its auxiliary. Client H writes, but it may read only through a narrow window. A request that breaks the window rules is held back and leaves a sticky fault flag. Every issued read is answered one cycle later on the requesting client's own response channel. The response echoes the slot, index and lane mask, and carries the data that the memory returns on the port that served the read.

Top module: `prio_port_sched`

## Requirements
- R1: Client priority is fixed at 0 (P) over 1 (H) over 2 (X). Port 0 carries the operation of the highest-priority schedulable client, in the same combinational cycle.
- R2: A second access is issued on port 1 only when three conditions hold: the first client has a single operation, the candidate comes from a lower-priority schedulable client that also has a single operation, and the two are pair-legal. When several candidates qualify, the highest-priority one is taken.
- R3: Two operations are pair-legal unless they name the same slot and the same index while at least one of them is a write (we=1). Two reads of the same address are legal. A client whose two operations are not pair-legal cannot be scheduled.
- R4: A client with both descriptors enabled (op index 0 and 1) that wins sends op 0 to port 0 and op 1 to port 1. No other client is granted in that cycle.
- R5: Client H can be scheduled with a read (we=0) only when three conditions hold: hash_rd_en is high, every read slot lies in HWIN_LO..HWIN_HI (9..12 by default), and no write is present in the same request. In every other case its whole request cannot be scheduled.
- R6: `fault` becomes set at the clock edge after a cycle in which client H presented a read that breaks R5. It then stays set until reset.
- R7: `stall[c]` is high exactly when client c has at least one descriptor enabled and is granted no port.
- R8: One cycle after a port issues a read of op o for client c, `rsp_valid[c][o]` is high, `rsp_slot`, `rsp_idx` and `rsp_lanes` echo the issued values, and `rsp_data` equals `mem_rdata` of that port in the response cycle.
- R9: Two reads issued together return two responses in the same cycle, each on its own client/op channel.
- R10: While `rst_n` is low, `fault` and every `rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hash_rd_en | input | 1 | Opens the read window for client H |
| op_en | input | 3x2 | Descriptor enable per client and op index |
| op_we | input | 3x2 | 1 = write, 0 = read |
| op_slot | input | 3x2xSLOT_W | Polynomial slot ID |
| op_idx | input | 3x2xIDX_W | Coefficient-group index within the slot |
| op_lanes | input | 3x2xLANES | Lane-valid mask |
| op_wdata | input | 3x2xDATA_W | Write data |
| stall | output | 3 | Per-client stall |
| fault | output | 1 | Sticky illegal-read flag for client H |
| mem_en | output | 2 | Port enables |
| mem_we | output | 2 | Port write strobes |
| mem_slot | output | 2xSLOT_W | Port slot ID |
| mem_idx | output | 2xIDX_W | Port index |
| mem_lanes | output | 2xLANES | Port lane mask |
| mem_wdata | output | 2xDATA_W | Port write data |
| mem_rdata | input | 2xDATA_W | Read data from each port, one cycle after issue |
| rsp_valid | output | 3x2 | Response valid per client and op index |
| rsp_slot | output | 3x2xSLOT_W | Echoed slot ID |
| rsp_idx | output | 3x2xIDX_W | Echoed index |
| rsp_lanes | output | 3x2xLANES | Echoed lane mask |
| rsp_data | output | 3x2xDATA_W | Routed read data |

## Verification
The bench uses a 5-bit slot, a 2-bit index, 2 lanes and 8-bit data, and keeps the default window of 9..12. Slots are drawn from 8, 9, 12 and 13, and indices from 0 and 1. Both edges of the H window are therefore hit on each side, and same-address collisions between clients and within one client happen often. Thousands of mixed cycles cover every combination of single, combined and dual-descriptor requests, including dual-response cycles. A mid-run reset shows that the sticky fault clears.

// File: rtl/prio_port_sched.sv
module prio_port_sched #(
  parameter int SLOT_W  = 5,
  parameter int IDX_W   = 6,
  parameter int LANES   = 4,
  parameter int DATA_W  = 32,
  parameter int HWIN_LO = 9,
  parameter int HWIN_HI = 12
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                hash_rd_en,
  input  logic [2:0][1:0]                     op_en,
  input  logic [2:0][1:0]                     op_we,
  input  logic [2:0][1:0][SLOT_W-1:0]         op_slot,
  input  logic [2:0][1:0][IDX_W-1:0]          op_idx,
  input  logic [2:0][1:0][LANES-1:0]          op_lanes,
  input  logic [2:0][1:0][DATA_W-1:0]         op_wdata,
  output logic [2:0]                          stall,
  output logic                                fault,
  output logic [1:0]                          mem_en,
  output logic [1:0]                          mem_we,
  output logic [1:0][SLOT_W-1:0]              mem_slot,
  output logic [1:0][IDX_W-1:0]               mem_idx,
  output logic [1:0][LANES-1:0]               mem_lanes,
  output logic [1:0][DATA_W-1:0]              mem_wdata,
  input  logic [1:0][DATA_W-1:0]              mem_rdata,
  output logic [2:0][1:0]                     rsp_valid,
  output logic [2:0][1:0][SLOT_W-1:0]         rsp_slot,
  output logic [2:0][1:0][IDX_W-1:0]          rsp_idx,
  output logic [2:0][1:0][LANES-1:0]          rsp_lanes,
  output logic [2:0][1:0][DATA_W-1:0]         rsp_data
);

  localparam logic [SLOT_W-1:0] WLO = SLOT_W'(HWIN_LO);
  localparam logic [SLOT_W-1:0] WHI = SLOT_W'(HWIN_HI);

  function automatic logic clash(input logic [SLOT_W-1:0] sa, input logic [SLOT_W-1:0] sb,
                                 input logic [IDX_W-1:0] ia, input logic [IDX_W-1:0] ib,
                                 input logic wa, input logic wb);
    return (sa == sb) && (ia == ib) && (wa || wb);
  endfunction

  logic [2:0] req, two, one, sel, sched;
  logic       h_rd, h_wr, h_out, h_bad;
  logic       fv, sv;
  logic [1:0] fc, sc;
  logic [1:0][1:0] cs;
  logic [1:0]      os;

  always_comb begin
    for (int c = 0; c < 3; c++) begin
      req[c] = |op_en[c];
      two[c] = &op_en[c];
      one[c] = ^op_en[c];
      sel[c] = op_en[c][1] & ~op_en[c][0];
    end
    h_rd  = |(op_en[1] & ~op_we[1]);
    h_wr  = |(op_en[1] & op_we[1]);
    h_out = 1'b0;
    for (int o = 0; o < 2; o++)
      if (op_en[1][o] && !op_we[1][o] && (op_slot[1][o] < WLO || op_slot[1][o] > WHI))
        h_out = 1'b1;
    h_bad = h_rd && (!hash_rd_en || h_wr || h_out);
    for (int c = 0; c < 3; c++)
      sched[c] = req[c] && !(two[c] && clash(op_slot[c][0], op_slot[c][1], op_idx[c][0],
                                             op_idx[c][1], op_we[c][0], op_we[c][1]))
                 && !(c == 1 && h_bad);
  end

  always_comb begin
    fv = 1'b0;
    fc = 2'd0;
    for (int c = 2; c >= 0; c--)
      if (sched[c]) begin
        fv = 1'b1;
        fc = 2'(c);
      end
    sv = 1'b0;
    sc = 2'd0;
    for (int c = 2; c >= 0; c--)
      if (fv && !two[fc] && c > int'(fc) && sched[c] && one[c] &&
          !clash(op_slot[fc][sel[fc]], op_slot[c][sel[c]], op_idx[fc][sel[fc]],
                 op_idx[c][sel[c]], op_we[fc][sel[fc]], op_we[c][sel[c]])) begin
        sv = 1'b1;
        sc = 2'(c);
      end
  end

  always_comb begin
    cs[0] = fc;
    os[0] = two[fc] ? 1'b0 : sel[fc];
    cs[1] = two[fc] ? fc : sc;
    os[1] = two[fc] ? 1'b1 : sel[sc];
    mem_en = {fv & (two[fc] | sv), fv};
    for (int k = 0; k < 2; k++) begin
      mem_we[k]    = mem_en[k] & op_we[cs[k]][os[k]];
      mem_slot[k]  = mem_en[k] ? op_slot[cs[k]][os[k]]  : '0;
      mem_idx[k]   = mem_en[k] ? op_idx[cs[k]][os[k]]   : '0;
      mem_lanes[k] = mem_en[k] ? op_lanes[cs[k]][os[k]] : '0;
      mem_wdata[k] = mem_en[k] ? op_wdata[cs[k]][os[k]] : '0;
    end
    for (int c = 0; c < 3; c++)
      stall[c] = req[c] && !(fv && int'(fc) == c) && !(sv && int'(sc) == c);
  end

  logic [1:0]              rv;
  logic [1:0][1:0]         rc;
  logic [1:0]              ro;
  logic [1:0][SLOT_W-1:0]  rslot;
  logic [1:0][IDX_W-1:0]   ridx;
  logic [1:0][LANES-1:0]   rlanes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv <= '0; rc <= '0; ro <= '0; rslot <= '0; ridx <= '0; rlanes <= '0;
      fault <= 1'b0;
    end else begin
      rv     <= mem_en & ~mem_we;
      rc     <= cs;
      ro     <= os;
      rslot  <= mem_slot;
      ridx   <= mem_idx;
      rlanes <= mem_lanes;
      fault  <= fault | h_bad;
    end
  end

  always_comb begin
    rsp_valid = '0; rsp_slot = '0; rsp_idx = '0; rsp_lanes = '0; rsp_data = '0;
    for (int k = 0; k < 2; k++)
      if (rv[k]) begin
        rsp_valid[rc[k]][ro[k]] = 1'b1;
        rsp_slot[rc[k]][ro[k]]  = rslot[k];
        rsp_idx[rc[k]][ro[k]]   = ridx[k];
        rsp_lanes[rc[k]][ro[k]] = rlanes[k];
        rsp_data[rc[k]][ro[k]]  = mem_rdata[k];
      end
  end

  AST_TOP_CLIENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sched[0] |-> !stall[0]); // R1
  AST_NO_ADDR_HAZARD: assert property (@(posedge clk) disable iff (!rst_n)
    (&mem_en && mem_slot[0] == mem_slot[1] && mem_idx[0] == mem_idx[1]) |-> !(|mem_we)); // R3
  AST_ATOMIC_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (fv && two[fc]) |-> $countones(req & ~stall) == 1); // R4
  AST_H_READ_WINDOW0: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en[0] && !mem_we[0] && cs[0] == 2'd1) |-> (hash_rd_en && mem_slot[0] >= WLO && mem_slot[0] <= WHI)); // R5
  AST_H_READ_WINDOW1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en[1] && !mem_we[1] && cs[1] == 2'd1) |-> (hash_rd_en && mem_slot[1] >= WLO && mem_slot[1] <= WHI)); // R5
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault); // R6
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_valid) |-> $past(|(mem_en & ~mem_we))); // R8
  AST_RSP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rsp_valid) == $countones($past(mem_en & ~mem_we))); // R9

endmodule

// File: tb/prio_port_sched_bench.sv
module prio_port_sched_bench;
  localparam int SW = 5, IW = 2, LN = 2, DW = 8;

  logic clk = 1'b0, rst_n = 1'b0, hen = 1'b0;
  logic [2:0][1:0] en, we;
  logic [2:0][1:0][SW-1:0] sl;
  logic [2:0][1:0][IW-1:0] ix;
  logic [2:0][1:0][LN-1:0] ln;
  logic [2:0][1:0][DW-1:0] wd;
  logic [2:0] stall;
  logic fault;
  logic [1:0] mem_en, mem_we;
  logic [1:0][SW-1:0] mem_slot;
  logic [1:0][IW-1:0] mem_idx;
  logic [1:0][LN-1:0] mem_lanes;
  logic [1:0][DW-1:0] mem_wdata, rdata;
  logic [2:0][1:0] rsp_valid;
  logic [2:0][1:0][SW-1:0] rsp_slot;
  logic [2:0][1:0][IW-1:0] rsp_idx;
  logic [2:0][1:0][LN-1:0] rsp_lanes;
  logic [2:0][1:0][DW-1:0] rsp_data;

  always #4 clk = ~clk;

  prio_port_sched #(.SLOT_W(SW), .IDX_W(IW), .LANES(LN), .DATA_W(DW)) u_prio_port_sched (
    .clk(clk), .rst_n(rst_n), .hash_rd_en(hen),
    .op_en(en), .op_we(we), .op_slot(sl), .op_idx(ix), .op_lanes(ln), .op_wdata(wd),
    .stall(stall), .fault(fault),
    .mem_en(mem_en), .mem_we(mem_we), .mem_slot(mem_slot), .mem_idx(mem_idx),
    .mem_lanes(mem_lanes), .mem_wdata(mem_wdata), .mem_rdata(rdata),
    .rsp_valid(rsp_valid), .rsp_slot(rsp_slot), .rsp_idx(rsp_idx),
    .rsp_lanes(rsp_lanes), .rsp_data(rsp_data));

  int checks = 0, errors = 0, dual_rsp = 0, atomic_seen = 0, hread_seen = 0;
  bit done = 0;

  int  xc[2], xo[2];
  bit  xen[2];
  bit [2:0] xst;
  bit  xbad, fexp;
  bit  pv[2];
  int  pc[2], po[2];
  logic [SW-1:0] ps[2];
  logic [IW-1:0] pi[2];
  logic [LN-1:0] pl[2];

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic bit cl(int ca, int oa, int cb, int ob);
    return sl[ca][oa] == sl[cb][ob] && ix[ca][oa] == ix[cb][ob] && (we[ca][oa] || we[cb][ob]);
  endfunction

  task automatic model();
    bit ok[3];
    int n[3], s[3];
    int f = -1, g = -1;
    bit hr = 0, hw = 0, ho = 0;
    for (int o = 0; o < 2; o++)
      if (en[1][o]) begin
        if (we[1][o]) hw = 1;
        else begin
          hr = 1;
          if (sl[1][o] < 9 || sl[1][o] > 12) ho = 1;
        end
      end
    xbad = hr && (!hen || hw || ho);
    for (int c = 0; c < 3; c++) begin
      n[c] = int'(en[c][0]) + int'(en[c][1]);
      s[c] = en[c][0] ? 0 : 1;
      ok[c] = n[c] > 0 && !(n[c] == 2 && cl(c, 0, c, 1)) && !(c == 1 && xbad);
    end
    for (int c = 0; c < 3; c++) if (ok[c] && f < 0) f = c;
    if (f >= 0 && n[f] == 1)
      for (int c = f + 1; c < 3; c++)
        if (g < 0 && ok[c] && n[c] == 1 && !cl(f, s[f], c, s[c])) g = c;
    xen[0] = f >= 0;
    xen[1] = f >= 0 && (n[f] == 2 || g >= 0);
    if (f >= 0 && n[f] == 2) begin
      xc[0] = f; xo[0] = 0; xc[1] = f; xo[1] = 1; atomic_seen++;
    end else begin
      xc[0] = f < 0 ? 0 : f; xo[0] = f < 0 ? 0 : s[f];
      xc[1] = g < 0 ? 0 : g; xo[1] = g < 0 ? 0 : s[g];
    end
    for (int c = 0; c < 3; c++) xst[c] = n[c] > 0 && c != f && c != g;
  endtask

  task automatic randomize_req();
    logic [SW-1:0] pick[4] = '{5'd8, 5'd9, 5'd12, 5'd13};
    for (int c = 0; c < 3; c++)
      for (int o = 0; o < 2; o++) begin
        en[c][o] = ($urandom % 3) == 0;
        we[c][o] = $urandom % 2;
        sl[c][o] = pick[$urandom % 4];
        ix[c][o] = IW'($urandom % 2);
        ln[c][o] = LN'($urandom);
        wd[c][o] = DW'($urandom);
      end
    hen = ($urandom % 4) != 0;
  endtask

  task automatic step();
    bit exp_v;
    int nv = 0;
    @(negedge clk);
    for (int k = 0; k < 2; k++) rdata[k] = DW'($urandom);
    randomize_req();
    #1;
    for (int c = 0; c < 3; c++)
      for (int o = 0; o < 2; o++) begin
        exp_v = 0;
        for (int k = 0; k < 2; k++)
          if (pv[k] && pc[k] == c && po[k] == o) begin
            exp_v = 1;
            chk(rsp_slot[c][o] == ps[k] && rsp_idx[c][o] == pi[k] && rsp_lanes[c][o] == pl[k]
                && rsp_data[c][o] == rdata[k], "R8 rsp echo/data",
                {rsp_slot[c][o], rsp_idx[c][o], rsp_lanes[c][o], rsp_data[c][o]},
                {ps[k], pi[k], pl[k], rdata[k]});
          end
        if (exp_v) nv++;
        chk(rsp_valid[c][o] == exp_v, "R8 R9 rsp_valid", rsp_valid[c][o], exp_v);
      end
    if (nv == 2) dual_rsp++;
    chk(fault == fexp, "R6 fault", fault, fexp);
    model();
    for (int k = 0; k < 2; k++) begin
      chk(mem_en[k] == xen[k], "R1 R2 R4 port enable", mem_en[k], xen[k]);
      if (xen[k]) begin
        chk(mem_we[k] == we[xc[k]][xo[k]] && mem_slot[k] == sl[xc[k]][xo[k]] &&
            mem_idx[k] == ix[xc[k]][xo[k]] && mem_lanes[k] == ln[xc[k]][xo[k]] &&
            mem_wdata[k] == wd[xc[k]][xo[k]], "R1 R2 R3 R4 R5 port content",
            {mem_we[k], mem_slot[k], mem_idx[k], mem_wdata[k]},
            {we[xc[k]][xo[k]], sl[xc[k]][xo[k]], ix[xc[k]][xo[k]], wd[xc[k]][xo[k]]});
        if (xc[k] == 1 && !we[1][xo[k]]) hread_seen++;
      end
      pv[k] = xen[k] && !we[xc[k]][xo[k]];
      pc[k] = xc[k]; po[k] = xo[k];
      ps[k] = sl[xc[k]][xo[k]]; pi[k] = ix[xc[k]][xo[k]]; pl[k] = ln[xc[k]][xo[k]];
    end
    chk(stall == xst, "R7 stall", stall, xst);
    fexp = fexp | xbad;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    en = '0; we = '0; sl = '0; ix = '0; ln = '0; wd = '0; rdata = '0;
    @(negedge clk);
    chk(rsp_valid == '0, "R10 rsp_valid in reset", rsp_valid, 0);
    chk(fault == 1'b0, "R10 R6 fault in reset", fault, 0);
    chk(stall == '0 && mem_en == '0, "R7 idle in reset", {stall, mem_en}, 0);
    rst_n = 1;
    fexp = 0;
    pv[0] = 0; pv[1] = 0;
  endtask

  initial begin
    do_reset();
    for (int i = 0; i < 3000; i++) step();
    chk(fexp == 1'b1, "R6 fault reached", fexp, 1);
    do_reset();
    for (int i = 0; i < 3000; i++) step();
    chk(dual_rsp > 0, "R9 dual responses occurred", dual_rsp, 1);
    chk(atomic_seen > 0, "R4 atomic grants occurred", atomic_seen, 1);
    chk(hread_seen > 0, "R5 window reads occurred", hread_seen, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=expired expected=finished");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule